// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block is a 32-pin general-purpose I/O bank. Each pin can be set as an input or an output. Every input is brought into the clock domain through a two-stage synchronizer. It is then tested against a per-pin trigger condition: low level, high level, rising edge, falling edge, or either edge.

When a condition is met, a sticky status bit is set. This happens whatever the mask says. Software reads the status and clears bits by writing ones. The mask only decides which status bits reach the two aggregate interrupt lines, one for the lower sixteen pins and one for the upper sixteen.

All state sits behind a small register port. A write takes effect at the clock edge where `reg_we` is high. A read returns a registered value one cycle after the address is presented.

Top module: `gpio_irq_bank`

## Requirements
- R1: While `rst` is high at a clock edge, every register (data, direction, both trigger registers, any-edge, mask, status) clears to zero. `pad_oe`, `pad_out`, `reg_rdata`, `irq_lo` and `irq_hi` are all zero one cycle later.
- R2: Register address 1 holds the direction. A bit of 1 makes the pin an output. `pad_oe` equals the direction register and `pad_out` equals the data register (address 0), each visible in the cycle after the write.
- R3: Reading address 0 returns the driven data bit for output pins. For input pins it returns the pad value delayed through two synchronizing flops.
- R4: Each pin has a 2-bit trigger code: 00 low level, 01 high level, 10 rising edge, 11 falling edge. Pins 0–15 use address 2 and pins 16–31 use address 3. Pin p occupies bits [2*(p mod 16)+1 : 2*(p mod 16)]. An edge is found by comparing the synchronized sample with the previous synchronized sample.
- R5: Address 4 holds the any-edge select. When a pin's bit is 1, its trigger code is ignored and both rising and falling edges set its status.
- R6: A status bit (address 6) is set when its condition is met, whatever the mask. It then stays set until it is cleared.
- R7: Writing 1 to a status bit position clears it, and writing 0 leaves it unchanged. If a detection hits the same bit in the same cycle as the clear, the bit stays set.
- R8: A level trigger sets the status bit again on every cycle in which the level persists, so a clear during an active level does not take effect.
- R9: Address 5 holds the mask. `irq_lo` is the registered OR of status bits 0–15 ANDed with their mask bits, and `irq_hi` does the same for bits 16–31. Both lag the status by one cycle.
- R10: `reg_rdata` shows the register selected by `reg_addr` one cycle after it is presented, taken before any same-cycle write. Address 7 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Asynchronous pad inputs |
| pad_out | output | 32 | Driven pad values |
| pad_oe | output | 32 | Pad output enables |
| irq_lo | output | 1 | Aggregate interrupt, pins 0–15 |
| irq_hi | output | 1 | Aggregate interrupt, pins 16–31 |

## Verification
The assertions assume that `reset` is asserted from time zero for at least one edge. They also assume that the register port inputs are stable across each clock edge, and that pad inputs change only away from the sampling edge, so that the synchronizer never sees a metastable value. The bench changes every input on the falling clock edge, which keeps each one steady through the rising edge. It toggles pins one cycle at a time, so that a status clear and a fresh detection meet in the same cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [2:0] {
    A_DATA  = 3'd0,
    A_DIR   = 3'd1,
    A_TRGLO = 3'd2,
    A_TRGHI = 3'd3,
    A_ANY   = 3'd4,
    A_MASK  = 3'd5,
    A_STAT  = 3'd6,
    A_NONE  = 3'd7
  } reg_addr_e;

  localparam logic [1:0] TRG_LOW  = 2'b00;
  localparam logic [1:0] TRG_HIGH = 2'b01;
  localparam logic [1:0] TRG_RISE = 2'b10;
  localparam logic [1:0] TRG_FALL = 2'b11;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= din;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect
  import gpio_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   smp,
  input  logic [2*W-1:0] trig,
  input  logic [W-1:0]   any_edge,
  output logic [W-1:0]   hit
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= smp;
  end

  for (genvar p = 0; p < W; p++) begin : g_pin
    logic [1:0] code;
    logic       rise, fall;
    assign code = trig[2*p +: 2];
    assign rise = smp[p] & ~prev_q[p];
    assign fall = ~smp[p] & prev_q[p];
    always_comb begin
      if (any_edge[p]) begin
        hit[p] = rise | fall;
      end else begin
        case (code)
          TRG_LOW:  hit[p] = ~smp[p];
          TRG_HIGH: hit[p] = smp[p];
          TRG_RISE: hit[p] = rise;
          default:  hit[p] = fall;
        endcase
      end
    end
  end

  // a rising edge on a pin in any-edge mode must be reported
  p_anyedge_rise_r5: assert property (@(posedge clk) disable iff (rst)
    ((any_edge & smp & ~prev_q) != '0) |->
      ((hit & any_edge & smp & ~prev_q) == (any_edge & smp & ~prev_q)));
endmodule

// File: rtl/gpio_status.sv
module gpio_status #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] hit,
  input  logic [W-1:0] clr,
  input  logic [W-1:0] mask,
  output logic [W-1:0] status,
  output logic         irq_lo,
  output logic         irq_hi
);
  localparam int HALF = W / 2;

  logic [W-1:0] status_q;
  logic [W-1:0] pend;

  assign pend = status_q & mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      irq_lo   <= 1'b0;
      irq_hi   <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr) | hit;
      irq_lo   <= |pend[HALF-1:0];
      irq_hi   <= |pend[W-1:HALF];
    end
  end

  assign status = status_q;

  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (clr == '0) |=> ((status_q & $past(status_q)) == $past(status_q)));

  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (hit != '0) |=> ((status_q & $past(hit)) == $past(hit)));

  p_mask_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |=> (!irq_lo && !irq_hi));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_we,
  input  logic [2:0]      reg_addr,
  input  logic [NPIN-1:0] reg_wdata,
  output logic [NPIN-1:0] reg_rdata,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic            irq_lo,
  output logic            irq_hi
);
  localparam int HALF = NPIN / 2;

  reg_addr_e       sel;
  logic [NPIN-1:0] data_q, dir_q, trglo_q, trghi_q, any_q, mask_q;
  logic [NPIN-1:0] smp, hit, clr, status;
  logic [NPIN-1:0] rd_mux;

  assign sel = reg_addr_e'(reg_addr);

  gpio_sync #(.W(NPIN), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .din(pad_in), .dout(smp)
  );

  gpio_detect #(.W(NPIN)) u_det (
    .clk(clk), .rst(rst), .smp(smp),
    .trig({trghi_q, trglo_q}), .any_edge(any_q), .hit(hit)
  );

  assign clr = (reg_we && sel == A_STAT) ? reg_wdata : '0;

  gpio_status #(.W(NPIN)) u_stat (
    .clk(clk), .rst(rst), .hit(hit), .clr(clr), .mask(mask_q),
    .status(status), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      dir_q   <= '0;
      trglo_q <= '0;
      trghi_q <= '0;
      any_q   <= '0;
      mask_q  <= '0;
    end else if (reg_we) begin
      case (sel)
        A_DATA:  data_q  <= reg_wdata;
        A_DIR:   dir_q   <= reg_wdata;
        A_TRGLO: trglo_q <= reg_wdata;
        A_TRGHI: trghi_q <= reg_wdata;
        A_ANY:   any_q   <= reg_wdata;
        A_MASK:  mask_q  <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      A_DATA:  rd_mux = (smp & ~dir_q) | (data_q & dir_q);
      A_DIR:   rd_mux = dir_q;
      A_TRGLO: rd_mux = trglo_q;
      A_TRGHI: rd_mux = trghi_q;
      A_ANY:   rd_mux = any_q;
      A_MASK:  rd_mux = mask_q;
      A_STAT:  rd_mux = status;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  assign pad_out = data_q;
  assign pad_oe  = dir_q;

  p_dir_to_oe_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_we && sel == A_DIR) |=> (pad_oe == $past(reg_wdata)));

  p_hole_reads_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (sel == A_NONE) |=> (reg_rdata == '0));
endmodule

// File: tb/gpio_irq_bank_bench.sv
module gpio_irq_bank_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] pad_in = '0;
  logic [31:0] rdata, pad_out, pad_oe;
  logic        irq_lo, irq_hi;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 0;
  string phase = "R1";

  gpio_irq_bank u_gpio_irq_bank (
    .clk(clk), .rst(rst), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  always #(CLK_P/2) clk = ~clk;

  // behavioural reference, advanced at every rising edge
  logic [31:0] m_s1, m_s2, m_prev, m_data, m_dir, m_tlo, m_thi, m_any, m_mask, m_stat, m_rd;
  logic        m_ilo, m_ihi;
  initial begin
    {m_s1, m_s2, m_prev, m_data, m_dir, m_tlo, m_thi, m_any, m_mask, m_stat, m_rd} = '0;
    m_ilo = 0; m_ihi = 0;
  end

  function automatic logic [31:0] model_read(input int a);
    case (a)
      0: return (m_s2 & ~m_dir) | (m_data & m_dir);
      1: return m_dir;
      2: return m_tlo;
      3: return m_thi;
      4: return m_any;
      5: return m_mask;
      6: return m_stat;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      {m_s1, m_s2, m_prev, m_data, m_dir, m_tlo, m_thi, m_any, m_mask, m_stat, m_rd} = '0;
      m_ilo = 0; m_ihi = 0;
    end else begin
      logic [31:0] h;
      logic [31:0] c;
      h = '0;
      for (int p = 0; p < 32; p++) begin
        int code;
        bit r, f;
        code = (p < 16) ? int'((m_tlo >> (2*p)) & 3) : int'((m_thi >> (2*(p-16))) & 3);
        r = m_s2[p] && !m_prev[p];
        f = !m_s2[p] && m_prev[p];
        if (m_any[p]) h[p] = r | f;
        else if (code == 0) h[p] = !m_s2[p];
        else if (code == 1) h[p] = m_s2[p];
        else if (code == 2) h[p] = r;
        else h[p] = f;
      end
      m_rd  = model_read(int'(addr));
      m_ilo = ((m_stat & m_mask & 32'h0000FFFF) != 0);
      m_ihi = ((m_stat & m_mask & 32'hFFFF0000) != 0);
      c = (we && addr == 3'd6) ? wdata : '0;
      m_stat = (m_stat & ~c) | h;
      if (we) begin
        case (addr)
          3'd0: m_data = wdata;
          3'd1: m_dir  = wdata;
          3'd2: m_tlo  = wdata;
          3'd3: m_thi  = wdata;
          3'd4: m_any  = wdata;
          3'd5: m_mask = wdata;
          default: ;
        endcase
      end
      m_prev = m_s2;
      m_s2   = m_s1;
      m_s1   = pad_in;
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("rdata", rdata, m_rd);
      chk("pad_out", pad_out, m_data);
      chk("pad_oe", pad_oe, m_dir);
      chk("irq_lo", {31'd0, irq_lo}, {31'd0, m_ilo});
      chk("irq_hi", {31'd0, irq_hi}, {31'd0, m_ihi});
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = 3'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a);
    @(negedge clk);
    we = 1'b0; addr = 3'(a);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    // R1: reset state
    idle(3);
    chk("R1 reset rdata", rdata, 32'd0);
    chk("R1 reset oe", pad_oe, 32'd0);
    chk("R1 reset irq", {30'd0, irq_hi, irq_lo}, 32'd0);
    @(negedge clk); rst = 1'b0; pad_in = 32'hFFFF_FFFF;
    phase = "R8";                       // default low-level code catches the zero samples
    rd(6); idle(4); rd(6);
    phase = "R7";
    wr(6, 32'hFFFF_FFFF); rd(6); idle(2); rd(6);
    phase = "R2";
    wr(1, 32'h00FF_00F0); wr(0, 32'h1234_5678); idle(2);
    phase = "R3";
    @(negedge clk); pad_in = 32'h0F0F_3C3C;
    rd(0); rd(0); rd(0); rd(0);
    phase = "R4";
    wr(2, 32'h5555_5539); wr(3, 32'h5555_555E);
    @(negedge clk); pad_in = 32'hFFFF_FFFF; idle(4);
    wr(6, 32'hFFFF_FFFF);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); pad_in = pad_in ^ 32'h0003_000F;
      rd(6); rd(6);
    end
    phase = "R5";
    wr(4, 32'h0003_0002); wr(6, 32'hFFFF_FFFF);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); pad_in = pad_in ^ 32'h0003_0002;
      idle(3); rd(6); wr(6, 32'h0003_0002);
    end
    phase = "R6";
    wr(5, 32'h0); @(negedge clk); pad_in = pad_in ^ 32'h0001_0002; idle(4); rd(6); idle(3); rd(6);
    phase = "R9";
    wr(5, 32'h0001_0002); idle(3); wr(6, 32'h0001_0000); idle(2);
    wr(6, 32'h0000_0002); idle(3);
    @(negedge clk); pad_in = pad_in ^ 32'h0001_0000; idle(5);
    wr(5, 32'hFFFF_FFFF); idle(3); wr(5, 32'h0); idle(3);
    phase = "R7";
    wr(6, 32'h0); rd(6);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); pad_in = pad_in ^ 32'h0000_0002;
      we = 1'b1; addr = 3'd6; wdata = 32'h0000_0002;
    end
    @(negedge clk); we = 1'b0; rd(6); idle(3); rd(6);
    phase = "R8";
    wr(2, 32'h5555_5515); @(negedge clk); pad_in[3] = 1'b0; idle(4);
    for (int k = 0; k < 4; k++) wr(6, 32'h0000_0008);
    rd(6); @(negedge clk); pad_in[3] = 1'b1; idle(3); wr(6, 32'h0000_0008); rd(6);
    phase = "R10";
    for (int a = 0; a < 8; a++) rd(a);
    wr(5, 32'hA5A5_0F0F); addr = 3'd5; idle(2);
    idle(2);
    finish_run();
  end
endmodule